// File: doc/BRIEF.md
# DDR Read Data Strobe Capture

This block is the read-data capture path of a DDR SDRAM controller. It serves a 32-bit double-rate data bus split into four 8-bit byte lanes. Each lane has its own delayed data strobe and its own inverted copy of that strobe. The block samples both halves of every strobe period with rising-edge flip-flops only. The first beat is taken on the rising edge of the strobe. The second beat is taken on the rising edge of the inverted strobe. The first beat is then registered a second time on the inverted strobe, so both beats of a pair sit in the same clock domain before they leave the lane.

The four 16-bit lane pairs form one 64-bit word, which is retimed into the system clock domain. A static mode input selects how this is done. In direct mode the word is taken straight on the rising edge of the system clock. In half-cycle mode the word is first taken on the rising edge of an inverted system clock, which is supplied as a separate input. It is then taken on the next rising edge of the system clock, half a cycle later.

A read-valid flag from the system domain marks the cycles that carry burst data. The flag travels alongside the data, so every output word comes with its own valid bit. When a memory device has one shared strobe, that strobe is wired to all four lane strobe inputs.

Top module: `ddr_rd_capture`

## Requirements
- R1: While `rst_n` is low, `rd_valid` is 0 and `rd_data` is all zeros. Both stay that way until the first marked read word arrives.
- R2: The byte that lane n presents on `dq[8n+7:8n]` before the rising edge of `dqs[n]` appears in `rd_data[8n+7:8n]`.
- R3: The byte that lane n presents on `dq[8n+7:8n]` before the rising edge of `dqs_n[n]` appears in `rd_data[32+8n+7:32+8n]`.
- R4: During back-to-back strobe periods with no idle gap, each output word holds the two beats of exactly one strobe period. Beats from adjacent periods are never mixed.
- R5: With `retime_half` = 0, `rd_valid` and the matching word appear one system clock edge after the edge that samples `rd_valid_in` high.
- R6: With `retime_half` = 1, `rd_valid` and the matching word appear two system clock edges after the edge that samples `rd_valid_in` high. This is one cycle later than in R5.
- R7: Whenever `rd_valid` is 0, `rd_data` keeps its previous value. Bus activity on `dq` while the strobes are idle has no effect on it.
- R8: Capture is correct when all four lane strobes are identical (one shared strobe). It is also correct when the lanes are skewed against each other by up to a tenth of the clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clk_n | input | 1 | Inverted system clock, used for half-cycle retiming |
| rst_n | input | 1 | Asynchronous active-low reset |
| retime_half | input | 1 | 0: direct retime on the rising edge of `clk`; 1: retime on `clk_n`, then on `clk` |
| rd_valid_in | input | 1 | Marks system cycles whose strobe period carries read data |
| dqs | input | 4 | Delayed data strobe, one per lane |
| dqs_n | input | 4 | Inverted delayed data strobe, one per lane |
| dq | input | 32 | Double-rate read data bus |
| rd_valid | output | 1 | Output word is valid |
| rd_data | output | 64 | First beats in bits [31:0], second beats in bits [63:32], 8 bits per lane |

## Verification
The assertions check on every system cycle that the valid flag keeps the latency of the selected mode, that the output word never changes while the valid flag is low, and that reset clears the outputs. Only the bench scenarios can show that the data content is correct. That means correct byte placement per lane and beat, no mixing of beats across back-to-back strobe periods, and capture that still works when the strobes are shared or skewed between lanes. These scenarios drive the strobes as clocks skewed from the system clock and compare each word with a queued reference model.

// File: rtl/ddr_rdcap_pkg.sv
`timescale 1ns/100ps
package ddr_rdcap_pkg;

  // Retime selection into the system clock domain
  typedef enum logic {
    RT_DIRECT = 1'b0,  // rising edge of the system clock only
    RT_HALF   = 1'b1   // inverted system clock, then system clock
  } rt_mode_e;

endpackage

// File: rtl/rdcap_reset_sync.sv
`timescale 1ns/100ps
// Reset synchronizer: asserts asynchronously, releases on the system clock.
module rdcap_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/rdcap_lane.sv
`timescale 1ns/100ps
// One byte lane: both beats captured with rising-edge flops only.
// Beat one is captured on the strobe and then moved into the inverted-strobe domain.
module rdcap_lane #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         strb,
  input  logic         strb_inv,
  input  logic [W-1:0] dq,
  output logic [W-1:0] beat_first,
  output logic [W-1:0] beat_second
);

  logic [W-1:0] first_s_q;   // strobe domain
  logic [W-1:0] first_i_q;   // inverted-strobe domain
  logic [W-1:0] second_i_q;  // inverted-strobe domain
  logic [W-1:0] first_s_d;
  logic [W-1:0] first_i_d;
  logic [W-1:0] second_i_d;

  always_comb begin
    first_s_d  = dq;
    first_i_d  = first_s_q;
    second_i_d = dq;
  end

  always_ff @(posedge strb or negedge rst_n) begin
    if (!rst_n) begin
      first_s_q <= '0;
    end else begin
      first_s_q <= first_s_d;
    end
  end

  always_ff @(posedge strb_inv or negedge rst_n) begin
    if (!rst_n) begin
      first_i_q  <= '0;
      second_i_q <= '0;
    end else begin
      first_i_q  <= first_i_d;
      second_i_q <= second_i_d;
    end
  end

  assign beat_first  = first_i_q;
  assign beat_second = second_i_q;

endmodule

// File: rtl/rdcap_retime.sv
`timescale 1ns/100ps
// Retimes the assembled beat word into the system clock domain.
module rdcap_retime
  import ddr_rdcap_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          clk_n,
  input  logic          rst_n,
  input  rt_mode_e      mode,
  input  logic          vld_in,
  input  logic [DW-1:0] pair_in,
  output logic          vld_out,
  output logic [DW-1:0] data_out
);

  logic          half_sel;
  logic [DW-1:0] fall_q, fall_d;
  logic          fall_en;
  logic          vld_d1_q, vld_d1_d;
  logic          vld_out_q, vld_out_d;
  logic [DW-1:0] data_out_q, data_out_d;
  logic          src_vld;
  logic [DW-1:0] src_data;

  assign half_sel = (mode == RT_HALF);
  assign fall_en  = half_sel;

  always_comb begin
    fall_d = fall_q;
    if (fall_en) begin
      fall_d = pair_in;
    end
    vld_d1_d   = vld_in;
    src_vld    = half_sel ? vld_d1_q : vld_in;
    src_data   = half_sel ? fall_q   : pair_in;
    vld_out_d  = src_vld;
    data_out_d = data_out_q;
    if (src_vld) begin
      data_out_d = src_data;
    end
  end

  // Half-cycle stage on the inverted system clock
  always_ff @(posedge clk_n or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
    end else begin
      fall_q <= fall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_d1_q   <= 1'b0;
      vld_out_q  <= 1'b0;
      data_out_q <= '0;
    end else begin
      vld_d1_q   <= vld_d1_d;
      vld_out_q  <= vld_out_d;
      data_out_q <= data_out_d;
    end
  end

  assign vld_out  = vld_out_q;
  assign data_out = data_out_q;

endmodule

// File: rtl/ddr_rd_capture.sv
`timescale 1ns/100ps
module ddr_rd_capture
  import ddr_rdcap_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       clk_n,
  input  logic                       rst_n,
  input  logic                       retime_half,
  input  logic                       rd_valid_in,
  input  logic [LANES-1:0]           dqs,
  input  logic [LANES-1:0]           dqs_n,
  input  logic [LANES*LANE_W-1:0]    dq,
  output logic                       rd_valid,
  output logic [2*LANES*LANE_W-1:0]  rd_data
);

  localparam int BUS_W  = LANES * LANE_W;
  localparam int DATA_W = 2 * BUS_W;

  logic              rst_sync_n;
  rt_mode_e          mode_sel;
  logic [DATA_W-1:0] pair_bus;

  assign mode_sel = rt_mode_e'(retime_half);

  rdcap_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdcap_lane #(.W(LANE_W)) u_lane (
      .rst_n       (rst_n),
      .strb        (dqs[g]),
      .strb_inv    (dqs_n[g]),
      .dq          (dq[g*LANE_W +: LANE_W]),
      .beat_first  (pair_bus[g*LANE_W +: LANE_W]),
      .beat_second (pair_bus[BUS_W + g*LANE_W +: LANE_W])
    );
  end

  rdcap_retime #(.DW(DATA_W)) u_retime (
    .clk      (clk),
    .clk_n    (clk_n),
    .rst_n    (rst_sync_n),
    .mode     (mode_sel),
    .vld_in   (rd_valid_in),
    .pair_in  (pair_bus),
    .vld_out  (rd_valid),
    .data_out (rd_data)
  );

endmodule

// File: rtl/ddr_rd_capture_chk.sv
`timescale 1ns/100ps
module ddr_rd_capture_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retime_half,
  input logic          rd_valid_in,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);

  // R1: outputs cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!rd_valid && rd_data == '0));

  // R5: direct mode latency of one edge
  a_r5_direct_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(retime_half) |-> (rd_valid == $past(rd_valid_in)));

  // R6: half-cycle mode latency of two edges
  a_r6_half_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retime_half) |-> (rd_valid == $past(rd_valid_in, 2)));

  // R7: output word holds while not valid
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.DW(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .retime_half (retime_half),
  .rd_valid_in (rd_valid_in),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data)
);

// File: tb/ddr_rd_capture_test.sv
`timescale 1ns/100ps
module ddr_rd_capture_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk;
  logic        clk_n;
  logic        rst_n;
  logic        retime_half;
  logic        rd_valid_in;
  logic [3:0]  dqs;
  logic [3:0]  dqs_n;
  logic [31:0] dq;
  logic        rd_valid;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int seed   = 1;

  logic [63:0] cur_word;
  bit          qv[$];
  logic [63:0] qd[$];
  logic        exp_valid;
  logic [63:0] exp_data;

  assign clk_n = ~clk;
  assign dqs_n = ~dqs;

  ddr_rd_capture uut (
    .clk         (clk),
    .clk_n       (clk_n),
    .rst_n       (rst_n),
    .retime_half (retime_half),
    .rd_valid_in (rd_valid_in),
    .dqs         (dqs),
    .dqs_n       (dqs_n),
    .dq          (dq),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reference model: queue of sampled (valid, word) per system edge
  always @(posedge clk) begin
    if (!rst_n) begin
      qv.delete();
      qd.delete();
      exp_valid = 1'b0;
      exp_data  = '0;
    end else begin
      int idx;
      qv.push_back(rd_valid_in);
      qd.push_back(cur_word);
      idx = retime_half ? qv.size() - 2 : qv.size() - 1;
      if (idx >= 0) begin
        exp_valid = qv[idx];
        if (qv[idx]) exp_data = qd[idx];
      end else begin
        exp_valid = 1'b0;
      end
      if (qv.size() > 4) begin
        void'(qv.pop_front());
        void'(qd.pop_front());
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(retime_half ? "R6" : "R5", "valid", 64'(rd_valid), 64'(exp_valid));
      check(exp_valid ? "R2" : "R7", "first beats", 64'(rd_data[31:0]), 64'(exp_data[31:0]));
      check(exp_valid ? "R3" : "R7", "second beats", 64'(rd_data[63:32]), 64'(exp_data[63:32]));
      if (rd_valid) vcount++;
    end
  end

  function automatic logic [63:0] make_word(input int s);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = 8'((s * 29 + b * 53 + 7) & 255);
    return w;
  endfunction

  // One system cycle; strobe rises 2 ns after the edge, falls 5 ns later
  task automatic drive_cycle(input bit v, input logic [63:0] w, input bit skew);
    @(posedge clk);
    #1;
    rd_valid_in = v;
    if (v) begin
      cur_word = w;
      dq = w[31:0];
      #1   dqs = skew ? 4'b0011 : 4'b1111;
      #1   dqs = 4'b1111;
      #1.5 dq  = w[63:32];
      #2.5 dqs = skew ? 4'b1100 : 4'b0000;
      #1   dqs = 4'b0000;
    end else begin
      dq = 32'hC3C3_0000 | 32'(seed & 16'hFFFF);
      seed++;
    end
  endtask

  task automatic run_scen(input string tag, input bit half, input bit skew,
                          input int bursts, input int blen, input int gap);
    int base;
    @(posedge clk);
    #1 retime_half = half;
    repeat (3) drive_cycle(1'b0, '0, 1'b0);
    base = vcount;
    for (int b = 0; b < bursts; b++) begin
      for (int i = 0; i < blen; i++) begin
        drive_cycle(1'b1, make_word(seed), skew);
        seed++;
      end
      repeat (gap) drive_cycle(1'b0, '0, 1'b0);
    end
    repeat (4) drive_cycle(1'b0, '0, 1'b0);
    check(tag, "valid word count", 64'(vcount - base), 64'(bursts * blen));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n       = 1'b1;
    retime_half = 1'b0;
    rd_valid_in = 1'b0;
    dqs         = 4'b0000;
    dq          = 32'h5A5A_A5A5;
    cur_word    = '0;
    #1 rst_n = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R1", "valid in reset", 64'(rd_valid), 64'd0);
      check("R1", "data in reset", rd_data, 64'd0);
    end
    #3 rst_n = 1'b1;
    repeat (4) drive_cycle(1'b0, '0, 1'b0);

    run_scen("R5", 1'b0, 1'b0, 2, 4, 2);  // direct mode, shared strobe
    run_scen("R4", 1'b0, 1'b0, 1, 8, 0);  // back-to-back periods, direct
    run_scen("R6", 1'b1, 1'b0, 2, 4, 2);  // half-cycle mode
    run_scen("R4", 1'b1, 1'b0, 1, 8, 0);  // back-to-back periods, half
    run_scen("R8", 1'b0, 1'b1, 1, 6, 1);  // skewed lanes, direct
    run_scen("R8", 1'b1, 1'b1, 1, 6, 1);  // skewed lanes, half
    run_scen("R8", 1'b1, 1'b0, 1, 5, 1);  // identical strobes, half
    run_scen("R7", 1'b0, 1'b0, 3, 1, 3);  // isolated words with idle bus noise
    finish_sim();
  end

endmodule